// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block merges every reset request of a chip into one core reset. Five requests come from inside the chip: power-on, brown-out, a watchdog time-out that is armed to reset, a wake alarm that arrives while the chip sleeps, and a debug reset command. The sixth is an active-low external pin. The pin works in both directions: the block drives it low through an open-drain pull-down to show that the chip is in reset, and it also reads the pin as a reset request. The pin input is the level driven by the external requester, sensed apart from the block's own pull-down, so the block's indication never counts as a new request.

After any request goes away, the block holds the core in reset for a fixed stabilisation count of clock cycles. A request that is still active holds the count at zero, and a new request during the count starts it again. The external pin passes through a synchroniser and must read low for several cycles in a row before it counts as a request. If the pin is still low when the count runs out, the core stays in reset until the pin has read high for several cycles in a row. While the core is in reset, the program-counter value and the GPIO direction word sent to the rest of the chip are forced to their safe values. A cause register records which sources started the current or most recent reset.

Top module: `sys_reset_seq`

## Requirements
- R1: An internal request counts only when it is qualified. Brown-out and debug count directly. The watchdog time-out counts only while its reset-enable input is 1. The alarm counts only while the sleep input is 1. An unqualified watchdog or alarm leaves core_rst_o at 0 and leaves cause_o unchanged.
- R2: Power-on or any qualified internal request asserts core_rst_o and pin_pull_o in the same cycle, without waiting for a clock edge. core_rst_o falls only at a rising clock edge.
- R3: If the last clock edge at which power-on or an internal request was sampled high is edge E, and the pin is released, core_rst_o falls at edge E+HOLD_CYCLES (default 1025). It stays high while the request stays asserted.
- R4: The pin passes through SYNC_STAGES flops (default 2). It counts as a request only after LOW_QUAL (default 3) consecutive synchronised low samples. With the defaults, a pin driven low before edge a1 asserts core_rst_o after edge a5. A pin held low for 2 cycles has no effect.
- R5: For a qualified external request, the hold count starts at the edge after qualification. With the defaults, a 3-cycle low pulse that starts before edge a1 releases core_rst_o at edge a1031.
- R6: pin_pull_o is 1 from the start of any reset event until the hold count expires, and 0 after that, even if core_rst_o is still high.
- R7: If the synchronised pin has not read high for HIGH_QUAL (default 4) consecutive samples when the count expires, core_rst_o stays high. It falls at the edge after that run of high samples completes: 7 edges after the pin is driven high, with the defaults.
- R8: A new request during the hold count, or at the expiry edge itself, restarts the count from zero. Release then comes HOLD_CYCLES edges after the new request is last sampled.
- R9: cause_o bits are: 0 power-on, 1 brown-out, 2 pin, 3 watchdog, 4 alarm, 5 debug. Power-on sets cause_o to 6'b000001. A request that arrives while the core is running replaces cause_o with its own bits. A request that arrives during an ongoing reset ORs its bits in.
- R10: While core_rst_o is 1, pc_o is all zeros and gpio_dir_o is all ones (1 = input). Otherwise both outputs pass pc_i and gpio_dir_i through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high; also the block's own synchronous reset |
| brown_i | input | 1 | Brown-out request |
| wdog_tmo_i | input | 1 | Watchdog time-out |
| wdog_rst_en_i | input | 1 | Watchdog time-out is allowed to reset |
| alarm_i | input | 1 | Clock alarm |
| sleep_i | input | 1 | Chip is in sleep mode |
| dbg_rst_i | input | 1 | Debug reset command |
| pin_rst_n_i | input | 1 | External reset requester level, active low, asynchronous |
| pin_pull_o | output | 1 | Open-drain pull-down enable for the reset pin |
| core_rst_o | output | 1 | Core reset, active high |
| cause_o | output | 6 | Reset cause bits |
| pc_i | input | 24 | Program counter value from the core |
| pc_o | output | 24 | Program counter value, zeroed in reset |
| gpio_dir_i | input | 8 | GPIO direction word (1 = input) |
| gpio_dir_o | output | 8 | GPIO direction word, all inputs in reset |

## Verification
The hold counter can see two things in the same cycle: its own expiry, and the arrival of a fresh request. The bench provokes this by releasing a brown-out pulse and then timing a debug command so that it is sampled on exactly the edge where the count would expire. The check passes only if the restart wins: core reset and the pull-down stay high, the debug bit joins the cause bits, and release comes a full hold period after the debug command. A second collision comes from a brown-out that arrives while the block waits on a pin that is still low. That brown-out must send the block back into counting, with the pull-down asserted again. A behavioural model compares every output on every clock through both collisions.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    localparam int unsigned NUM_SRC   = 6;
    localparam int unsigned SRC_POR   = 0;
    localparam int unsigned SRC_BROWN = 1;
    localparam int unsigned SRC_PIN   = 2;
    localparam int unsigned SRC_WDOG  = 3;
    localparam int unsigned SRC_ALARM = 4;
    localparam int unsigned SRC_DEBUG = 5;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Sequencer phase: running, counting the hold period, waiting on the pin.
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HOLD = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic brown;
        logic wdog_tmo;
        logic wdog_arm;
        logic alarm;
        logic asleep;
        logic debug;
    } int_req_t;

    // Gate the raw internal inputs and place each request on its cause bit.
    function automatic src_vec_t build_requests(int_req_t r, logic pin_hit);
        src_vec_t v;
        v            = '0;
        v[SRC_BROWN] = r.brown;
        v[SRC_WDOG]  = r.wdog_tmo & r.wdog_arm;
        v[SRC_ALARM] = r.alarm & r.asleep;
        v[SRC_DEBUG] = r.debug;
        v[SRC_PIN]   = pin_hit;
        return v;
    endfunction

    function automatic logic phase_holds_core(phase_e p);
        return p != PH_RUN;
    endfunction

    function automatic logic phase_drives_pin(phase_e p);
        return p == PH_HOLD;
    endfunction

endpackage

// File: rtl/rstseq_run_counter.sv
`timescale 1ns/1ps
module rstseq_run_counter #(
    parameter int unsigned LIMIT = 3,
    parameter bit          PULSE = 1'b0
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic match_i,
    output logic flag_o
);
    localparam int unsigned    CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  TOP = CW'(LIMIT);
    localparam logic [CW-1:0]  PRE = CW'(LIMIT - 1);

    logic [CW-1:0] run_q;

    // Length of the current run of matching samples, saturating at LIMIT.
    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            run_q <= '0;
        end else if (!match_i) begin
            run_q <= '0;
        end else if (run_q != TOP) begin
            run_q <= run_q + CW'(1);
        end
    end

    generate
        if (PULSE) begin : g_pulse
            logic hit_q;
            always_ff @(posedge clk_i) begin
                if (clr_i) begin
                    hit_q <= 1'b0;
                end else begin
                    hit_q <= match_i && (run_q == PRE);
                end
            end
            assign flag_o = hit_q;

            p_single_hit_r4: assert property (@(posedge clk_i) disable iff (clr_i)
                hit_q |=> !hit_q);
        end else begin : g_level
            assign flag_o = (run_q == TOP);
        end
    endgenerate

endmodule

// File: rtl/rstseq_pin_qual.sv
`timescale 1ns/1ps
module rstseq_pin_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_QUAL    = 3,
    parameter int unsigned HIGH_QUAL   = 4
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic pin_n_i,
    output logic fire_o,
    output logic high_ok_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    rstseq_run_counter #(.LIMIT(LOW_QUAL), .PULSE(1'b1)) u_low_run (
        .clk_i   (clk_i),
        .clr_i   (clr_i),
        .match_i (!pin_s),
        .flag_o  (fire_o)
    );

    rstseq_run_counter #(.LIMIT(HIGH_QUAL), .PULSE(1'b0)) u_high_run (
        .clk_i   (clk_i),
        .clr_i   (clr_i),
        .match_i (pin_s),
        .flag_o  (high_ok_o)
    );

endmodule

// File: rtl/rstseq_hold_fsm.sv
`timescale 1ns/1ps
module rstseq_hold_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 1025
) (
    input  logic     clk_i,
    input  logic     por_i,
    input  src_vec_t req_i,
    input  logic     high_ok_i,
    output phase_e   phase_o,
    output src_vec_t cause_o
);
    localparam int unsigned   CW   = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    src_vec_t      cause_q;
    logic          any_req;

    assign any_req = |req_i;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
            cause_q <= src_vec_t'(1) << SRC_POR;
        end else if (any_req) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
            cause_q <= ((phase_q == PH_RUN) ? '0 : cause_q) | req_i;
        end else begin
            case (phase_q)
                PH_HOLD: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        phase_q <= high_ok_i ? PH_RUN : PH_WAIT;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_WAIT: begin
                    if (high_ok_i) begin
                        phase_q <= PH_RUN;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign phase_o = phase_q;
    assign cause_o = cause_q;

    p_restart_on_req_r8: assert property (@(posedge clk_i) disable iff (por_i)
        any_req |=> (cnt_q == '0) && (phase_q == PH_HOLD));

    p_hold_until_limit_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (phase_q == PH_HOLD && !any_req && cnt_q != LAST) |=> phase_q == PH_HOLD);

    p_wait_for_pin_r7: assert property (@(posedge clk_i) disable iff (por_i)
        (phase_q == PH_WAIT && !high_ok_i && !any_req) |=> phase_q == PH_WAIT);

    p_cause_present_r9: assert property (@(posedge clk_i) disable iff (por_i)
        phase_q != PH_RUN |-> cause_q != '0);

endmodule

// File: rtl/sys_reset_seq.sv
`timescale 1ns/1ps
module sys_reset_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 1025,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_QUAL    = 3,
    parameter int unsigned HIGH_QUAL   = 4,
    parameter int unsigned PC_W        = 24,
    parameter int unsigned GPIO_W      = 8
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              brown_i,
    input  logic              wdog_tmo_i,
    input  logic              wdog_rst_en_i,
    input  logic              alarm_i,
    input  logic              sleep_i,
    input  logic              dbg_rst_i,
    input  logic              pin_rst_n_i,
    output logic              pin_pull_o,
    output logic              core_rst_o,
    output logic [5:0]        cause_o,
    input  logic [PC_W-1:0]   pc_i,
    output logic [PC_W-1:0]   pc_o,
    input  logic [GPIO_W-1:0] gpio_dir_i,
    output logic [GPIO_W-1:0] gpio_dir_o
);
    int_req_t int_req;
    src_vec_t req_vec;
    src_vec_t cause_vec;
    phase_e   phase;
    logic     pin_fire;
    logic     pin_high_ok;
    logic     live_req;

    rstseq_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .LOW_QUAL    (LOW_QUAL),
        .HIGH_QUAL   (HIGH_QUAL)
    ) u_pin_qual (
        .clk_i     (clk),
        .clr_i     (por_i),
        .pin_n_i   (pin_rst_n_i),
        .fire_o    (pin_fire),
        .high_ok_o (pin_high_ok)
    );

    assign int_req = '{
        brown:    brown_i,
        wdog_tmo: wdog_tmo_i,
        wdog_arm: wdog_rst_en_i,
        alarm:    alarm_i,
        asleep:   sleep_i,
        debug:    dbg_rst_i
    };

    assign req_vec = build_requests(int_req, pin_fire);

    rstseq_hold_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk_i     (clk),
        .por_i     (por_i),
        .req_i     (req_vec),
        .high_ok_i (pin_high_ok),
        .phase_o   (phase),
        .cause_o   (cause_vec)
    );

    // Requests raise reset immediately; release only follows the registered phase.
    assign live_req   = por_i | (|req_vec);
    assign core_rst_o = live_req | phase_holds_core(phase);
    assign pin_pull_o = live_req | phase_drives_pin(phase);
    assign cause_o    = cause_vec;
    assign pc_o       = core_rst_o ? '0 : pc_i;
    assign gpio_dir_o = core_rst_o ? '1 : gpio_dir_i;

    p_pull_implies_core_r6: assert property (@(posedge clk) disable iff (por_i)
        pin_pull_o |-> core_rst_o);

endmodule

// File: tb/sys_reset_seq_test.sv
`timescale 1ns/1ps
module sys_reset_seq_test;

    localparam int HOLD = 1025;
    localparam int LOWQ = 3;
    localparam int HIGHQ = 4;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        brown = 1'b0;
    logic        wtmo = 1'b0;
    logic        wen = 1'b0;
    logic        alarm = 1'b0;
    logic        sleep = 1'b0;
    logic        dbg = 1'b0;
    logic        pin_n = 1'b1;
    logic [23:0] pc_in = 24'h5A5A5A;
    logic [7:0]  dir_in = 8'h0F;

    logic        pull, core;
    logic [5:0]  cause;
    logic [23:0] pc_out;
    logic [7:0]  dir_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sys_reset_seq uut (
        .clk           (clk),
        .por_i         (por),
        .brown_i       (brown),
        .wdog_tmo_i    (wtmo),
        .wdog_rst_en_i (wen),
        .alarm_i       (alarm),
        .sleep_i       (sleep),
        .dbg_rst_i     (dbg),
        .pin_rst_n_i   (pin_n),
        .pin_pull_o    (pull),
        .core_rst_o    (core),
        .cause_o       (cause),
        .pc_i          (pc_in),
        .pc_o          (pc_out),
        .gpio_dir_i    (dir_in),
        .gpio_dir_o    (dir_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_phase = 1;     // 0 running, 1 counting, 2 waiting on pin
    int        m_left = HOLD;
    logic [5:0] m_cause = 6'b000001;
    bit        m_seen[$] = '{1'b1, 1'b1};
    int        low_run = 0;
    int        high_run = 0;
    bit        m_fire = 1'b0;
    bit        started = 1'b0;

    function automatic logic [5:0] internal_bits();
        return {dbg, alarm & sleep, wtmo & wen, 1'b0, brown, 1'b0};
    endfunction

    always @(posedge clk) begin
        logic [5:0] req;
        bit         s_old;
        req = internal_bits() | (m_fire ? 6'b000100 : 6'b000000);
        started = 1'b1;
        if (por) begin
            m_phase = 1; m_left = HOLD; m_cause = 6'b000001;
            m_seen = '{1'b1, 1'b1}; low_run = 0; high_run = 0; m_fire = 1'b0;
        end else begin
            if (req != 0) begin
                m_cause = ((m_phase == 0) ? 6'b0 : m_cause) | req;
                m_phase = 1; m_left = HOLD;
            end else if (m_phase == 1) begin
                m_left--;
                if (m_left == 0) m_phase = (high_run >= HIGHQ) ? 0 : 2;
            end else if (m_phase == 2) begin
                if (high_run >= HIGHQ) m_phase = 0;
            end
            s_old = m_seen[0];
            if (!s_old) begin low_run++; high_run = 0; end
            else begin high_run++; low_run = 0; end
            m_fire = (low_run == LOWQ);
            void'(m_seen.pop_front());
            m_seen.push_back(pin_n);
        end
    end

    always @(posedge clk) begin
        logic e_core, e_pull, live;
        #3;
        if (started && !done) begin
            live   = por | (|internal_bits()) | m_fire;
            e_core = live | (m_phase != 0);
            e_pull = live | (m_phase == 1);
            chk(core === e_core, "R3 model core_rst", 32'(core), 32'(e_core));
            chk(pull === e_pull, "R6 model pin_pull", 32'(pull), 32'(e_pull));
            chk(cause === m_cause, "R9 model cause", 32'(cause), 32'(m_cause));
            chk(pc_out === (e_core ? 24'h0 : pc_in), "R10 model pc",
                32'(pc_out), 32'(e_core ? 24'h0 : pc_in));
            chk(dir_out === (e_core ? 8'hFF : dir_in), "R10 model gpio dir",
                32'(dir_out), 32'(e_core ? 8'hFF : dir_in));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        tick(3);
        chk(core === 1'b1, "R2 core during power-on", 32'(core), 32'd1);
        chk(pc_out === 24'h0, "R10 pc forced", 32'(pc_out), 32'd0);
        chk(dir_out === 8'hFF, "R10 gpio all inputs", 32'(dir_out), 32'hFF);
        por = 1'b0;
        tick(HOLD - 1);
        chk(core === 1'b1, "R3 power-on still held", 32'(core), 32'd1);
        tick(1);
        chk(core === 1'b0, "R3 power-on release edge", 32'(core), 32'd0);
        chk(cause === 6'b000001, "R9 power-on cause", 32'(cause), 32'h01);
        pc_in = 24'h123456; dir_in = 8'h3C;
        tick(1);
        chk(pc_out === 24'h123456, "R10 pc pass", 32'(pc_out), 32'h123456);

        // R1: unqualified watchdog and alarm are ignored
        wtmo = 1'b1; alarm = 1'b1;
        tick(10);
        chk(core === 1'b0, "R1 unarmed watchdog/alarm ignored", 32'(core), 32'd0);
        chk(cause === 6'b000001, "R1 cause untouched", 32'(cause), 32'h01);
        wtmo = 1'b0; alarm = 1'b0;
        tick(2);

        // R2/R3: brown-out pulse, asynchronous assertion, exact release
        brown = 1'b1;
        #0.2;
        chk(core === 1'b1, "R2 async core assert", 32'(core), 32'd1);
        chk(pull === 1'b1, "R2 async pull assert", 32'(pull), 32'd1);
        tick(1);
        brown = 1'b0;
        tick(HOLD - 1);
        chk(core === 1'b1, "R3 brown-out held", 32'(core), 32'd1);
        chk(pull === 1'b1, "R6 pull during hold", 32'(pull), 32'd1);
        tick(1);
        chk(core === 1'b0, "R3 brown-out release", 32'(core), 32'd0);
        chk(pull === 1'b0, "R6 pull off at expiry", 32'(pull), 32'd0);
        chk(cause === 6'b000010, "R9 brown-out cause", 32'(cause), 32'h02);

        // R1/R3: armed watchdog held for 20 cycles
        wtmo = 1'b1; wen = 1'b1;
        tick(20);
        chk(core === 1'b1, "R3 held while cause active", 32'(core), 32'd1);
        wtmo = 1'b0;
        tick(HOLD - 1);
        chk(core === 1'b1, "R3 watchdog held", 32'(core), 32'd1);
        tick(1);
        chk(core === 1'b0, "R3 watchdog release", 32'(core), 32'd0);
        chk(cause === 6'b001000, "R1 armed watchdog cause", 32'(cause), 32'h08);
        wen = 1'b0;

        // R1: alarm during sleep
        sleep = 1'b1; alarm = 1'b1;
        tick(1);
        alarm = 1'b0; sleep = 1'b0;
        tick(HOLD);
        chk(core === 1'b0, "R1 alarm release", 32'(core), 32'd0);
        chk(cause === 6'b010000, "R1 alarm cause", 32'(cause), 32'h10);

        // R4: 2-cycle glitch on pin ignored
        pin_n = 1'b0;
        tick(2);
        pin_n = 1'b1;
        tick(10);
        chk(core === 1'b0, "R4 short glitch ignored", 32'(core), 32'd0);

        // R4/R5: 3-cycle pulse qualifies, release at a1031
        pin_n = 1'b0;
        tick(3);
        pin_n = 1'b1;
        tick(1);
        chk(core === 1'b0, "R4 not yet qualified", 32'(core), 32'd0);
        tick(1);
        chk(core === 1'b1, "R4 qualified after a5", 32'(core), 32'd1);
        tick(HOLD);
        chk(core === 1'b1, "R5 held at a1030", 32'(core), 32'd1);
        tick(1);
        chk(core === 1'b0, "R5 release at a1031", 32'(core), 32'd0);
        chk(cause === 6'b000100, "R5 pin cause", 32'(cause), 32'h04);

        // R7: pin held past expiry
        pin_n = 1'b0;
        tick(1500);
        chk(core === 1'b1, "R7 held while pin low", 32'(core), 32'd1);
        chk(pull === 1'b0, "R6 pull off after expiry", 32'(pull), 32'd0);
        pin_n = 1'b1;
        tick(6);
        chk(core === 1'b1, "R7 waiting for high run", 32'(core), 32'd1);
        tick(1);
        chk(core === 1'b0, "R7 release after high run", 32'(core), 32'd0);

        // R8: new request exactly on the expiry edge
        brown = 1'b1;
        tick(1);
        brown = 1'b0;
        tick(HOLD - 1);
        dbg = 1'b1;
        tick(1);
        dbg = 1'b0;
        chk(core === 1'b1, "R8 restart beats expiry", 32'(core), 32'd1);
        chk(pull === 1'b1, "R8 pull kept on restart", 32'(pull), 32'd1);
        chk(cause === 6'b100010, "R9 causes accumulate", 32'(cause), 32'h22);
        tick(HOLD - 1);
        chk(core === 1'b1, "R8 restarted hold", 32'(core), 32'd1);
        tick(1);
        chk(core === 1'b0, "R8 release after restart", 32'(core), 32'd0);

        // R8: brown-out while waiting on a low pin, then power-on mid-hold
        pin_n = 1'b0;
        tick(1100);
        brown = 1'b1;
        tick(1);
        brown = 1'b0;
        chk(pull === 1'b1, "R8 pull back on in wait", 32'(pull), 32'd1);
        tick(200);
        pin_n = 1'b1;
        tick(300);
        por = 1'b1;
        tick(2);
        por = 1'b0;
        tick(1);
        chk(cause === 6'b000001, "R9 power-on clears causes", 32'(cause), 32'h01);
        tick(HOLD + 20);
        chk(core === 1'b0, "R3 final release", 32'(core), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule